// File: doc/BRIEF.md
# Manual Single-Step Sequencer

This block lets an operator advance the processor one instruction at a time from the console. In manual mode the processor's state machine stops at State 1, inside its time-2 envelope. At that point the instruction about to run sits in B. The block raises a timing-hold enable and keeps a continue enable low, so the timing chain stays where it is.

A complete press and release of the STEP pushbutton lowers the hold and raises continue for one pass through the chain. The processor then runs the instruction. When it reaches State 1 again, the block stops it once more. The instruction just run is then in I and the following one is in B.

The raw switch is sampled through a synchronizer of `SYNC_STAGES` flops. Two flops then record the step: one records the press, and the other records the release that follows it. Continue is always granted when the processor runs automatically or when the console is disabled. The block carries no data stream, so every pin is a plain control level.

Top module: `manual_step_seq`

## Requirements
- R1: During reset, and with manual mode, console enabled, State 1 and the time-2 envelope all asserted, `tmg_hold` is 1 and `cont_en` is 0.
- R2: In manual mode with the console enabled, while the processor is waiting in State 1 and no step is pending:
  - `cont_en` stays 0.
  - `tmg_hold` equals `t2_env`.
  - `tmg_hold` and `cont_en` are never 1 together.
- R3: Holding STEP down, for any number of cycles, never raises `cont_en` while the processor is in State 1.
- R4: A STEP release that follows a captured press raises `cont_en` and clears `tmg_hold`. Counting the raw release as applied before clock edge 1:
  - both outputs are unchanged after edge 2;
  - `cont_en` is 1 and `tmg_hold` is 0 after edge 3 (SYNC_STAGES = 2).
- R5: Each press and release yields one pass only. After the processor leaves State 1 and then re-enters it, `tmg_hold` is 1 and `cont_en` is 0 from the first clock edge that sees State 1 again.
- R6: When `manual_mode` is 0 (auto), `cont_en` is 1 and `tmg_hold` is 0, whatever the state and the STEP input.
- R7: When `console_en` is 0, `cont_en` is 1 and `tmg_hold` is 0, whatever the state and the STEP input.
- R8: While `state1` is 0, `cont_en` is 1 and `tmg_hold` is 0.
- R9: A press and release made entirely while `state1` is 0 is ignored. When State 1 is next reached, the processor holds (`tmg_hold` 1, `cont_en` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| manual_mode | input | 1 | 1 = manual, 0 = auto |
| console_en | input | 1 | 1 = console enabled |
| step_raw | input | 1 | Raw STEP switch, 1 = pressed (asynchronous) |
| state1 | input | 1 | Processor is in State 1 |
| t2_env | input | 1 | Timing chain is in the time-2 envelope |
| tmg_hold | output | 1 | Timing-enable hold term, 1 = hold the chain |
| cont_en | output | 1 | Continue enable, 1 = chain may advance |

## Verification
The mode, state and time-2 inputs reach the outputs combinationally. The bench therefore checks those results at the falling edge that follows the change.

A STEP edge reaches the outputs only on the third rising edge, after two synchronizer flops and one capture flop. The bench looks both after the second edge, where nothing may have changed yet, and after the third, where the change is due.

Re-arming takes a single edge once State 1 returns, so the hold is checked one falling edge after `state1` is raised. All inputs change on falling edges and all samples are taken on falling edges, so no check depends on the order of processes at a rising edge.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  // Condition under which the console has no authority over sequencing.
  function automatic logic free_run(input logic manual_mode, input logic console_en);
    return !manual_mode || !console_en;
  endfunction
endpackage

// File: rtl/mstep_sync.sv
module mstep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_sync = chain_q[LAST];
endmodule

// File: rtl/mstep_capture.sv
module mstep_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic free_run,
  input  logic step_s,
  input  logic state1,
  output logic pressed_q,
  output logic released_q
);
  logic left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pressed_q  <= 1'b0;
      released_q <= 1'b0;
      left_q     <= 1'b0;
    end else if (free_run) begin
      pressed_q  <= 1'b0;
      released_q <= 1'b0;
      left_q     <= 1'b0;
    end else if (!released_q) begin
      if (state1 && step_s) pressed_q <= 1'b1;
      if (pressed_q && !step_s) begin
        released_q <= 1'b1;
        pressed_q  <= 1'b0;
      end
    end else begin
      if (!state1) left_q <= 1'b1;
      if (left_q && state1) begin
        released_q <= 1'b0;
        left_q     <= 1'b0;
      end
    end
  end

  AST_RELEASE_AFTER_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released_q) |-> $past(pressed_q)); // R4
  AST_REARM_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q && state1 && released_q) |=> !released_q); // R5
  AST_RELEASE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released_q) |-> $past(!step_s)); // R3
endmodule

// File: rtl/mstep_gate.sv
module mstep_gate (
  input  logic free_run,
  input  logic released_q,
  input  logic state1,
  input  logic t2_env,
  output logic tmg_hold,
  output logic cont_en
);
  always_comb begin
    cont_en  = free_run || !state1 || released_q;
    tmg_hold = !free_run && state1 && t2_env && !released_q;
  end
endmodule

// File: rtl/manual_step_seq.sv
module manual_step_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic manual_mode,
  input  logic console_en,
  input  logic step_raw,
  input  logic state1,
  input  logic t2_env,
  output logic tmg_hold,
  output logic cont_en
);
  import mstep_pkg::*;

  logic step_s, pressed_q, released_q, free_r;

  assign free_r = free_run(manual_mode, console_en);

  mstep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(step_raw), .q_sync(step_s));

  mstep_capture u_cap (
    .clk(clk), .rst_n(rst_n), .free_run(free_r), .step_s(step_s),
    .state1(state1), .pressed_q(pressed_q), .released_q(released_q));

  mstep_gate u_gate (
    .free_run(free_r), .released_q(released_q), .state1(state1),
    .t2_env(t2_env), .tmg_hold(tmg_hold), .cont_en(cont_en));

  AST_HOLD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tmg_hold |-> !cont_en); // R2
  AST_AUTO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_mode |-> (cont_en && !tmg_hold)); // R6
  AST_DISABLED_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !console_en |-> (cont_en && !tmg_hold)); // R7
  AST_OUTSIDE_STATE1: assert property (@(posedge clk) disable iff (!rst_n)
    !state1 |-> cont_en); // R8
  AST_PRESSED_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pressed_q && state1 && manual_mode && console_en) |-> !cont_en); // R3
endmodule

// File: tb/test_manual_step_seq.sv
module test_manual_step_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic manual_mode = 1'b1, console_en = 1'b1, step_raw = 1'b0;
  logic state1 = 1'b1, t2_env = 1'b1;
  logic tmg_hold, cont_en;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  manual_step_seq i_manual_step_seq (
    .clk(clk), .rst_n(rst_n), .manual_mode(manual_mode), .console_en(console_en),
    .step_raw(step_raw), .state1(state1), .t2_env(t2_env),
    .tmg_hold(tmg_hold), .cont_en(cont_en));

  task automatic chk(input string req, input logic exp_hold, input logic exp_cont);
    checks++;
    if (tmg_hold !== exp_hold || cont_en !== exp_cont) begin
      failures++;
      $display("FAIL %s: hold=%b cont=%b expected hold=%b cont=%b",
               req, tmg_hold, cont_en, exp_hold, exp_cont);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R1", 1'b1, 1'b0);
    rst_n = 1'b1;
    cyc(3);
    chk("R2", 1'b1, 1'b0);
    t2_env = 1'b0; cyc(1);
    chk("R2", 1'b0, 1'b0);
    t2_env = 1'b1; cyc(1);
    chk("R2", 1'b1, 1'b0);
  endtask

  // One press-release; processor leaves State 1 and comes back.
  task automatic t_step(input int hold_cycles);
    step_raw = 1'b1; cyc(hold_cycles);
    chk("R3", 1'b1, 1'b0);
    step_raw = 1'b0; cyc(2);
    chk("R4", 1'b1, 1'b0);
    cyc(1);
    chk("R4", 1'b0, 1'b1);
    state1 = 1'b0; t2_env = 1'b0; cyc(3);
    chk("R8", 1'b0, 1'b1);
    state1 = 1'b1; t2_env = 1'b1; cyc(1);
    chk("R5", 1'b1, 1'b0);
    cyc(4);
    chk("R5", 1'b1, 1'b0);
  endtask

  task automatic t_modes();
    manual_mode = 1'b0; step_raw = 1'b1; cyc(1);
    chk("R6", 1'b0, 1'b1);
    step_raw = 1'b0; cyc(4);
    chk("R6", 1'b0, 1'b1);
    manual_mode = 1'b1; cyc(1);
    chk("R6", 1'b1, 1'b0);
    console_en = 1'b0; cyc(1);
    chk("R7", 1'b0, 1'b1);
    console_en = 1'b1; cyc(1);
    chk("R7", 1'b1, 1'b0);
  endtask

  task automatic t_outside_press();
    state1 = 1'b0; t2_env = 1'b0; cyc(1);
    step_raw = 1'b1; cyc(4);
    step_raw = 1'b0; cyc(4);
    chk("R8", 1'b0, 1'b1);
    state1 = 1'b1; t2_env = 1'b1; cyc(2);
    chk("R9", 1'b1, 1'b0);
    cyc(4);
    chk("R9", 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_step(3);
    t_step(40);
    t_modes();
    t_outside_press();
    t_step(5);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        cyc(20000);
        failures++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule